// File: doc/BRIEF.md
# Register Move Elimination Unit

This unit sits beside the rename stage. For each register-to-register move it decides, in the same cycle, whether the move can be retired by pointing the destination at the source's value. When it can, no new physical register is spent. To make that decision it tracks, for every architectural register, a bit saying the register is known to hold zero and a pointer to the register whose value it currently shares. For every register bank it also counts how many moves were eliminated in the current cycle.

Architectural registers are flat and split evenly into banks. The last register of each bank is a narrow register. Renaming treats it as the lower part of the register just below it, which is called the wide register. Ordinary writes reported by the rename stage reset the alias and set the zero knowledge. Reads look up the alias port to find which register really produces their value.

Top module: `mv_elim_unit`

## Requirements
- R1: Register 0 is invalid. A move whose source or destination is 0 is never eliminated. A write to register 0 changes nothing, and a lookup of register 0 returns alias 0 with the zero flag low.
- R2: Register r belongs to bank r / (NUM_REGS/NUM_BANKS), which gives banks 0 (registers 0-7) and 1 (8-15) by default. A move between registers of different banks is never eliminated.
- R3: Each bank has a per-cycle limit, BANK_MAX (default bank 0: 2, bank 1: 0). Once that many moves of a bank have been eliminated since the last cycle-start pulse, further moves of that bank are rejected. A limit of 0 means there is no limit.
- R4: A cycle-start pulse sets every bank count to zero. A move presented in the same cycle as the pulse is judged against a count of zero.
- R5: In a bank whose ZERO_ONLY bit is set (default bank 1 only), a move is eliminated only while its source is known to hold zero.
- R6: A move whose destination is a narrow register (index RPB-1 within its bank) is eliminated only if two conditions hold: the bank's WIDE_MOVE_OK bit is set (default bank 0 yes, bank 1 no), and the move clears the full register (mv_clr_full).
- R7: The alias recorded for an eliminated move starts from the source's rename target. That target is the wide register if the source is narrow, and the source itself otherwise. If the target holds an alias, that alias replaces it, one level only. The result is stored as the destination's alias unless it equals the destination.
- R8: mv_zero is high exactly when a move is eliminated and its source is known zero. After an elimination, the destination's known-zero bit takes the source's value.
- R9: A normal write to register r clears r's alias and sets r's known-zero bit to wr_zero.
- R10: rd_alias returns the alias of rd_reg if one is held, and rd_reg itself otherwise. rd_zero returns rd_reg's known-zero bit.
- R11: When a normal write and an eliminated move target the same register in one cycle, that register's alias and zero bit follow the write.
- R12: After reset no register has an alias, no register is known zero, and all bank counts are zero.
- R13: mv_elim, mv_zero, rd_alias and rd_zero are combinational. All state changes appear after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | Marks the first cycle of a new rename cycle; clears bank counts |
| mv_req | input | 1 | A move is presented for elimination |
| mv_src | input | REG_W | Source register of the move |
| mv_dst | input | REG_W | Destination register of the move |
| mv_clr_full | input | 1 | The move's write clears the whole wide register |
| wr_valid | input | 1 | A normal (non-eliminated) write is reported |
| wr_reg | input | REG_W | Register of the normal write |
| wr_zero | input | 1 | The normal write is a zero idiom |
| rd_reg | input | REG_W | Register looked up for a read |
| mv_elim | output | 1 | The presented move is eliminated |
| mv_zero | output | 1 | The eliminated move carries a known-zero value |
| rd_alias | output | REG_W | Register that produces the value of rd_reg |
| rd_zero | output | 1 | rd_reg is known to hold zero |

## Verification
The bench walks the per-cycle limit up to its edge. A counter that compares with the wrong sign would grant a third move in bank 0 or refuse the second. It places moves in the same cycle as the cycle-start pulse, so a design that clears late would reject them. It builds an alias chain two deep. A design that follows the chain further, or not at all, would report the wrong producer on the lookup port. It also hits a write and a move on the same register in one cycle, narrow destinations with and without a full clear, zero-only moves before and after a zero idiom, and an unlimited bank whose count saturates. A wrong priority or a count that wraps would show up as a wrong alias, a wrong zero flag or a refused move.

// File: rtl/mv_pkg.sv
package mv_pkg;

    // Why a move request was not granted; RJ_NONE means granted.
    typedef enum logic [2:0] {
        RJ_IDLE,
        RJ_BADREG,
        RJ_BANK,
        RJ_NARROW,
        RJ_CAP,
        RJ_NOTZERO,
        RJ_NONE
    } reject_e;

    // Result of the elimination decision for one move.
    typedef struct packed {
        logic    grant;
        logic    zero;
        logic    rec_alias;
        reject_e why;
    } decision_t;

    function automatic int bank_of(int r, int rpb);
        return r / rpb;
    endfunction

    function automatic bit is_narrow(int r, int rpb);
        return (r % rpb) == (rpb - 1);
    endfunction

endpackage

// File: rtl/mv_decide.sv
module mv_decide
    import mv_pkg::*;
#(
    parameter int NUM_REGS  = 16,
    parameter int NUM_BANKS = 2,
    parameter int CNT_W     = 3,
    parameter int REG_W     = $clog2(NUM_REGS),
    parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    parameter logic [NUM_BANKS-1:0][CNT_W-1:0] BANK_MAX = {3'd0, 3'd2},
    parameter logic [NUM_BANKS-1:0] ZERO_ONLY    = 2'b10,
    parameter logic [NUM_BANKS-1:0] WIDE_MOVE_OK = 2'b01
) (
    input  logic                                mv_req,
    input  logic [REG_W-1:0]                    mv_src,
    input  logic [REG_W-1:0]                    mv_dst,
    input  logic                                mv_clr_full,
    input  logic                                cyc_start,
    input  logic [NUM_BANKS-1:0][CNT_W-1:0]     cnt_q,
    input  logic [NUM_REGS-1:0]                 zero_q,
    input  logic [NUM_REGS-1:0][REG_W-1:0]      alias_q,
    output decision_t                           dec,
    output logic [BANK_W-1:0]                   dec_bank,
    output logic [REG_W-1:0]                    dec_alias
);
    localparam int RPB = NUM_REGS / NUM_BANKS;

    logic [BANK_W-1:0] s_bank, d_bank;
    logic [CNT_W-1:0]  used;
    logic [REG_W-1:0]  tgt;
    logic              d_narrow;
    logic              cap_hit;
    reject_e           why;

    always_comb begin
        s_bank   = BANK_W'(bank_of(int'(mv_src), RPB));
        d_bank   = BANK_W'(bank_of(int'(mv_dst), RPB));
        d_narrow = is_narrow(int'(mv_dst), RPB);
        used     = cyc_start ? '0 : cnt_q[s_bank];
        cap_hit  = (BANK_MAX[s_bank] != '0) && (used >= BANK_MAX[s_bank]);

        if (!mv_req)
            why = RJ_IDLE;
        else if (mv_src == '0 || mv_dst == '0)
            why = RJ_BADREG;
        else if (s_bank != d_bank)
            why = RJ_BANK;
        else if (d_narrow && !(WIDE_MOVE_OK[d_bank] && mv_clr_full))
            why = RJ_NARROW;
        else if (cap_hit)
            why = RJ_CAP;
        else if (ZERO_ONLY[s_bank] && !zero_q[mv_src])
            why = RJ_NOTZERO;
        else
            why = RJ_NONE;

        // Rename target of the source, then one alias hop.
        tgt = is_narrow(int'(mv_src), RPB) ? mv_src - 1'b1 : mv_src;
        dec_alias = (alias_q[tgt] != '0) ? alias_q[tgt] : tgt;

        dec.why       = why;
        dec.grant     = (why == RJ_NONE);
        dec.zero      = dec.grant && zero_q[mv_src];
        dec.rec_alias = dec.grant && (dec_alias != mv_dst);
        dec_bank      = s_bank;
    end

endmodule

// File: rtl/mv_bank_ctr.sv
module mv_bank_ctr #(
    parameter int NUM_BANKS = 2,
    parameter int CNT_W     = 3,
    parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            cyc_start,
    input  logic                            inc,
    input  logic [BANK_W-1:0]               inc_bank,
    output logic [NUM_BANKS-1:0][CNT_W-1:0] cnt_q
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [CNT_W-1:0] base;
        assign base = cyc_start ? '0 : cnt_q[b];

        always_ff @(posedge clk) begin
            if (rst)
                cnt_q[b] <= '0;
            else if (inc && inc_bank == BANK_W'(b))
                cnt_q[b] <= (base == '1) ? base : base + 1'b1;
            else if (cyc_start)
                cnt_q[b] <= '0;
        end
    end

endmodule

// File: rtl/mv_reg_state.sv
module mv_reg_state #(
    parameter int NUM_REGS = 16,
    parameter int REG_W    = $clog2(NUM_REGS)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           el_grant,
    input  logic                           el_rec_alias,
    input  logic [REG_W-1:0]               el_dst,
    input  logic [REG_W-1:0]               el_alias,
    input  logic                           el_zero,
    input  logic                           wr_valid,
    input  logic [REG_W-1:0]               wr_reg,
    input  logic                           wr_zero,
    output logic [NUM_REGS-1:0][REG_W-1:0] alias_q,
    output logic [NUM_REGS-1:0]            zero_q
);
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        if (r == 0) begin : g_invalid
            assign alias_q[r] = '0;
            assign zero_q[r]  = 1'b0;
        end else begin : g_live
            logic hit_wr, hit_el;
            assign hit_wr = wr_valid && (wr_reg == REG_W'(r));
            assign hit_el = el_grant && (el_dst == REG_W'(r));

            always_ff @(posedge clk) begin
                if (rst) begin
                    alias_q[r] <= '0;
                    zero_q[r]  <= 1'b0;
                end else if (hit_wr) begin
                    alias_q[r] <= '0;
                    zero_q[r]  <= wr_zero;
                end else if (hit_el) begin
                    zero_q[r] <= el_zero;
                    if (el_rec_alias)
                        alias_q[r] <= el_alias;
                end
            end
        end
    end

endmodule

// File: rtl/mv_elim_unit.sv
module mv_elim_unit
    import mv_pkg::*;
#(
    parameter int NUM_REGS  = 16,
    parameter int NUM_BANKS = 2,
    parameter int CNT_W     = 3,
    parameter int REG_W     = $clog2(NUM_REGS),
    parameter logic [NUM_BANKS-1:0][CNT_W-1:0] BANK_MAX = {3'd0, 3'd2},
    parameter logic [NUM_BANKS-1:0] ZERO_ONLY    = 2'b10,
    parameter logic [NUM_BANKS-1:0] WIDE_MOVE_OK = 2'b01
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_start,
    input  logic             mv_req,
    input  logic [REG_W-1:0] mv_src,
    input  logic [REG_W-1:0] mv_dst,
    input  logic             mv_clr_full,
    input  logic             wr_valid,
    input  logic [REG_W-1:0] wr_reg,
    input  logic             wr_zero,
    input  logic [REG_W-1:0] rd_reg,
    output logic             mv_elim,
    output logic             mv_zero,
    output logic [REG_W-1:0] rd_alias,
    output logic             rd_zero
);
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    logic [NUM_BANKS-1:0][CNT_W-1:0] cnt_q;
    logic [NUM_REGS-1:0]             zero_q;
    logic [NUM_REGS-1:0][REG_W-1:0]  alias_q;
    decision_t                       dec;
    logic [BANK_W-1:0]               dec_bank;
    logic [REG_W-1:0]                dec_alias;

    mv_decide #(
        .NUM_REGS(NUM_REGS), .NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W),
        .REG_W(REG_W), .BANK_W(BANK_W), .BANK_MAX(BANK_MAX),
        .ZERO_ONLY(ZERO_ONLY), .WIDE_MOVE_OK(WIDE_MOVE_OK)
    ) u_decide (
        .mv_req(mv_req), .mv_src(mv_src), .mv_dst(mv_dst),
        .mv_clr_full(mv_clr_full), .cyc_start(cyc_start),
        .cnt_q(cnt_q), .zero_q(zero_q), .alias_q(alias_q),
        .dec(dec), .dec_bank(dec_bank), .dec_alias(dec_alias)
    );

    mv_bank_ctr #(
        .NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W), .BANK_W(BANK_W)
    ) u_ctr (
        .clk(clk), .rst(rst), .cyc_start(cyc_start),
        .inc(dec.grant), .inc_bank(dec_bank), .cnt_q(cnt_q)
    );

    mv_reg_state #(
        .NUM_REGS(NUM_REGS), .REG_W(REG_W)
    ) u_state (
        .clk(clk), .rst(rst),
        .el_grant(dec.grant), .el_rec_alias(dec.rec_alias),
        .el_dst(mv_dst), .el_alias(dec_alias), .el_zero(dec.zero),
        .wr_valid(wr_valid), .wr_reg(wr_reg), .wr_zero(wr_zero),
        .alias_q(alias_q), .zero_q(zero_q)
    );

    assign mv_elim  = dec.grant;
    assign mv_zero  = dec.zero;
    assign rd_alias = (alias_q[rd_reg] != '0) ? alias_q[rd_reg] : rd_reg;
    assign rd_zero  = zero_q[rd_reg];

endmodule

// File: rtl/mv_elim_unit_chk.sv
module mv_elim_unit_chk #(
    parameter int NUM_REGS  = 16,
    parameter int NUM_BANKS = 2,
    parameter int CNT_W     = 3,
    parameter int REG_W     = $clog2(NUM_REGS),
    parameter logic [NUM_BANKS-1:0][CNT_W-1:0] BANK_MAX = {3'd0, 3'd2},
    parameter logic [NUM_BANKS-1:0] ZERO_ONLY = 2'b10
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           cyc_start,
    input logic                           mv_req,
    input logic [REG_W-1:0]               mv_src,
    input logic [REG_W-1:0]               mv_dst,
    input logic                           wr_valid,
    input logic [REG_W-1:0]               wr_reg,
    input logic                           wr_zero,
    input logic                           mv_elim,
    input logic                           mv_zero,
    input logic [NUM_BANKS-1:0][CNT_W-1:0] cnt_q,
    input logic [NUM_REGS-1:0]            zero_q,
    input logic [NUM_REGS-1:0][REG_W-1:0] alias_q
);
    localparam int RPB = NUM_REGS / NUM_BANKS;

    // R1: invalid register never eliminated
    a_r1_bad_reg: assert property (@(posedge clk) disable iff (rst)
        (mv_req && (mv_src == '0 || mv_dst == '0)) |-> !mv_elim);

    // R2: cross-bank moves rejected
    a_r2_cross_bank: assert property (@(posedge clk) disable iff (rst)
        (mv_req && ((int'(mv_src) / RPB) != (int'(mv_dst) / RPB))) |-> !mv_elim);

    // R5: zero-only bank eliminates only known-zero sources
    a_r5_zero_only: assert property (@(posedge clk) disable iff (rst)
        (mv_elim && ZERO_ONLY[int'(mv_src) / RPB]) |-> zero_q[mv_src]);

    // R8: zero flag only accompanies an elimination
    a_r8_zero_flag: assert property (@(posedge clk) disable iff (rst)
        mv_zero |-> mv_elim);

    // R9: normal write clears alias and loads zero knowledge
    a_r9_write_update: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_reg != '0) |=>
        (alias_q[$past(wr_reg)] == '0 && zero_q[$past(wr_reg)] == $past(wr_zero)));

    // R12: reset leaves no alias and no zero knowledge
    a_r12_reset_state: assert property (@(posedge clk)
        rst |=> (alias_q == '0 && zero_q == '0 && cnt_q == '0));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
        if (BANK_MAX[b] != '0) begin : g_capped
            // R3: count never passes the per-cycle limit
            a_r3_cap_kept: assert property (@(posedge clk) disable iff (rst)
                cnt_q[b] <= BANK_MAX[b]);
        end
        // R4: after a cycle-start pulse a count holds at most one grant
        a_r4_cycle_clear: assert property (@(posedge clk) disable iff (rst)
            cyc_start |=> (cnt_q[b] <= CNT_W'(1)));
    end

endmodule

bind mv_elim_unit mv_elim_unit_chk #(
    .NUM_REGS(NUM_REGS), .NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W),
    .REG_W(REG_W), .BANK_MAX(BANK_MAX), .ZERO_ONLY(ZERO_ONLY)
) u_chk (
    .clk(clk), .rst(rst), .cyc_start(cyc_start),
    .mv_req(mv_req), .mv_src(mv_src), .mv_dst(mv_dst),
    .wr_valid(wr_valid), .wr_reg(wr_reg), .wr_zero(wr_zero),
    .mv_elim(mv_elim), .mv_zero(mv_zero),
    .cnt_q(cnt_q), .zero_q(zero_q), .alias_q(alias_q)
);

// File: tb/mv_elim_unit_test.sv
module mv_elim_unit_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc_start = 1'b0;
    logic       mv_req = 1'b0;
    logic [3:0] mv_src = '0;
    logic [3:0] mv_dst = '0;
    logic       mv_clr_full = 1'b0;
    logic       wr_valid = 1'b0;
    logic [3:0] wr_reg = '0;
    logic       wr_zero = 1'b0;
    logic [3:0] rd_reg = '0;
    logic       mv_elim, mv_zero, rd_zero;
    logic [3:0] rd_alias;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mv_elim_unit uut (
        .clk(clk), .rst(rst), .cyc_start(cyc_start),
        .mv_req(mv_req), .mv_src(mv_src), .mv_dst(mv_dst),
        .mv_clr_full(mv_clr_full), .wr_valid(wr_valid), .wr_reg(wr_reg),
        .wr_zero(wr_zero), .rd_reg(rd_reg), .mv_elim(mv_elim),
        .mv_zero(mv_zero), .rd_alias(rd_alias), .rd_zero(rd_zero)
    );

    typedef struct packed {
        logic       cyc;
        logic       req;
        logic [3:0] src;
        logic [3:0] dst;
        logic       clr;
        logic       wr;
        logic [3:0] wreg;
        logic       wz;
        logic [3:0] rd;
        logic       e_ok;
        logic       e_zero;
        logic [3:0] e_alias;
        logic       e_rz;
    } vec_t;

    // cyc req src dst clr | wr wreg wz | rd | ok zero alias rzero
    localparam vec_t VEC [23] = '{
        '{1, 1,  1,  2, 0, 0,  0, 0,  2, 1, 0,  2, 0},
        '{0, 1,  3,  4, 0, 0,  0, 0,  2, 1, 0,  1, 0},
        '{0, 1,  5,  1, 0, 0,  0, 0,  4, 0, 0,  3, 0},
        '{1, 1,  5,  1, 0, 0,  0, 0,  1, 1, 0,  1, 0},
        '{1, 1,  2,  3, 0, 0,  0, 0,  1, 1, 0,  5, 0},
        '{1, 1,  1,  9, 0, 0,  0, 0,  3, 0, 0,  1, 0},
        '{1, 1,  9, 10, 0, 0,  0, 0,  9, 0, 0,  9, 0},
        '{0, 0,  0,  0, 0, 1,  9, 1,  9, 0, 0,  9, 0},
        '{0, 1,  9, 10, 0, 0,  0, 0,  9, 1, 1,  9, 1},
        '{0, 1,  1,  7, 0, 0,  0, 0, 10, 0, 0,  9, 1},
        '{0, 1,  1,  7, 1, 0,  0, 0,  7, 1, 0,  7, 0},
        '{1, 1, 10, 15, 1, 0,  0, 0,  7, 0, 0,  5, 0},
        '{0, 1, 10, 11, 0, 0,  0, 0, 15, 1, 1, 15, 0},
        '{1, 1,  0,  2, 0, 0,  0, 0, 11, 0, 0,  9, 1},
        '{0, 1,  3,  0, 0, 0,  0, 0,  2, 0, 0,  1, 0},
        '{0, 1,  5,  3, 0, 1,  3, 1,  3, 1, 0,  1, 0},
        '{0, 0,  0,  0, 0, 0,  0, 0,  3, 0, 0,  3, 1},
        '{0, 0,  0,  0, 0, 1, 10, 0, 10, 0, 0,  9, 1},
        '{0, 0,  0,  0, 0, 0,  0, 0, 10, 0, 0, 10, 0},
        '{0, 0,  0,  0, 0, 1,  0, 1,  0, 0, 0,  0, 0},
        '{0, 0,  0,  0, 0, 0,  0, 0,  0, 0, 0,  0, 0},
        '{0, 1,  4,  5, 0, 0,  0, 0,  0, 1, 0,  0, 0},
        '{0, 1,  4,  6, 0, 0,  0, 0,  0, 0, 0,  0, 0}
    };

    function automatic string tag_of(int i);
        case (i)
            0:  return "R12 R3";
            1:  return "R7 R10";
            2:  return "R3 limit";
            3:  return "R4";
            4:  return "R7 one hop";
            5:  return "R2";
            6:  return "R5";
            7:  return "R13";
            8:  return "R8";
            9:  return "R6 no clear";
            10: return "R6 allowed";
            11: return "R6 bank1";
            12: return "R5 R8";
            13: return "R1 src";
            14: return "R1 dst";
            15: return "R11";
            16: return "R11 after";
            17: return "R13 write";
            18: return "R9";
            19: return "R1 write";
            20: return "R1 ignored";
            21: return "R3 second";
            default: return "R3 third";
        endcase
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic idle_inputs();
        cyc_start = 0; mv_req = 0; mv_src = 0; mv_dst = 0; mv_clr_full = 0;
        wr_valid = 0; wr_reg = 0; wr_zero = 0; rd_reg = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // Vector walk: each entry occupies one cycle
        for (int i = 0; i < 23; i++) begin
            cyc_start   = VEC[i].cyc;
            mv_req      = VEC[i].req;
            mv_src      = VEC[i].src;
            mv_dst      = VEC[i].dst;
            mv_clr_full = VEC[i].clr;
            wr_valid    = VEC[i].wr;
            wr_reg      = VEC[i].wreg;
            wr_zero     = VEC[i].wz;
            rd_reg      = VEC[i].rd;
            #1;
            check(tag_of(i), "mv_elim",  int'(mv_elim),  int'(VEC[i].e_ok));
            check(tag_of(i), "mv_zero",  int'(mv_zero),  int'(VEC[i].e_zero));
            check(tag_of(i), "rd_alias", int'(rd_alias), int'(VEC[i].e_alias));
            check(tag_of(i), "rd_zero",  int'(rd_zero),  int'(VEC[i].e_rz));
            @(negedge clk);
        end

        // R12: reset in mid-run wipes aliases and zero knowledge
        idle_inputs();
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        rd_reg = 10;
        #1;
        check("R12", "rd_alias", int'(rd_alias), 10);
        check("R12", "rd_zero", int'(rd_zero), 0);
        rd_reg = 3;
        #1;
        check("R12", "rd_alias", int'(rd_alias), 3);
        // R12: bank 0 count cleared, two grants allowed with no pulse
        mv_req = 1; mv_src = 1; mv_dst = 2;
        #1;
        check("R12 R3", "mv_elim", int'(mv_elim), 1);
        @(negedge clk);
        mv_src = 3; mv_dst = 4;
        #1;
        check("R12 R3", "mv_elim", int'(mv_elim), 1);
        @(negedge clk);
        idle_inputs();

        // R3: bank 1 has no limit; count saturates without refusing
        wr_valid = 1; wr_reg = 12; wr_zero = 1;
        @(negedge clk);
        idle_inputs();
        for (int k = 0; k < 10; k++) begin
            mv_req = 1; mv_src = 12; mv_dst = 13;
            #1;
            check("R3 unlimited", "mv_elim", int'(mv_elim), 1);
            check("R3 R8 unlimited", "mv_zero", int'(mv_zero), 1);
            @(negedge clk);
        end
        idle_inputs();
        rd_reg = 13;
        #1;
        check("R7 R8", "rd_alias", int'(rd_alias), 12);
        check("R8", "rd_zero", int'(rd_zero), 1);

        finish_run();
    end

endmodule